// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the serial front end of a byte-wide EEPROM model. A host drives chip select, serial clock and data-in in SPI mode 0. The engine decodes an 8-bit instruction. Depending on the instruction it toggles a write-enable latch, returns a status byte, takes a new status value, streams bytes out of a synchronous memory array, or stores one byte into it. Everything moves most significant bit first.

The SPI pins are treated as ordinary inputs that are synchronous to the system clock. The engine finds serial-clock and chip-select edges by comparing each pin with its value one clock earlier. Programming requests wait until chip select rises on a byte boundary, and they commit only if the write-enable latch is set and the protection check passes. A commit starts an internal busy window of `BUSY_CYC` clocks. At the end of that window the latch is cleared.

The array holds `2**AW` bytes. A 16 KB part uses AW = 14. The default is smaller so that elaboration stays light.

Top module: `eespi_slave`

## Requirements
- R1: Data-in is sampled on serial-clock rising edges and data-out changes after falling edges, MSB first; while chip select is high, miso is 0 and the bit position returns to zero.
- R2: An instruction is recognised only when bits 7:4 are zero, and bit 3 is ignored; bits 2:0 select 110 set-latch, 100 clear-latch, 101 status read, 001 status write, 011 read, 010 write.
- R3: The write-enable latch is 0 after reset. The set-latch instruction sets it. The clear-latch instruction clears it whatever the level of wp_n.
- R4: A status read returns {prot_en, 000, blk[1:0], wel, busy}, with busy in bit 0 and prot_en in bit 7, and repeats it for every further byte in the frame. While busy, it returns 0xFF instead.
- R5: Read and write take a 16-bit address whose bits above AW-1 are ignored. A read streams bytes from consecutive addresses and wraps from 2**AW-1 to 0.
- R6: A write stores only the first data byte after the address. It commits only when chip select rises with a whole number of bytes sent, the latch is set, and the address is not protected. In any other case the memory and the busy state are unchanged.
- R7: A status write copies data bits 3:2 into blk and bit 7 into prot_en, under the same commit rule as R6. It is refused while wp_n is low and prot_en is 1.
- R8: blk selects the write-protected part of the array: 0 none, 1 the top quarter, 2 the top half, 3 all of it. A refused write leaves the latch set.
- R9: Each commit makes the engine busy for BUSY_CYC clocks, and the latch is cleared when the busy window ends.
- R10: While busy, every instruction except the status read is ignored, including any status or memory change.
- R11: After an unrecognised instruction byte, the rest of the frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data to the host |

## Verification
The assertions assume that sck, cs_n and mosi are synchronous to clk. They also assume that each serial-clock level lasts at least two clocks, so that a memory read issued at a rising edge has returned before the falling edge that loads it. Chip select is assumed to change only while sck is low. The bench meets these assumptions by driving every pin on the falling clock edge and holding each serial-clock phase for four clocks. It asserts and releases chip select only after sck has settled low.

// File: rtl/eespi_pkg.sv
package eespi_pkg;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_RDAT, ST_WDAT, ST_SRRD, ST_SRWR, ST_SKIP
  } eespi_st_e;

  // low three opcode bits; the encoding is the decoded behaviour
  localparam logic [2:0] OP_WRSR  = 3'b001;
  localparam logic [2:0] OP_WRITE = 3'b010;
  localparam logic [2:0] OP_READ  = 3'b011;
  localparam logic [2:0] OP_WRDI  = 3'b100;
  localparam logic [2:0] OP_RDSR  = 3'b101;
  localparam logic [2:0] OP_WREN  = 3'b110;

  // blk level against the two top address bits
  function automatic logic blk_hit(input logic [1:0] lvl, input logic [1:0] top2);
    case (lvl)
      2'd1:    blk_hit = (top2 == 2'b11);
      2'd2:    blk_hit = top2[1];
      2'd3:    blk_hit = 1'b1;
      default: blk_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eespi_edge.sv
module eespi_edge #(
  parameter int          N    = 2,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= INIT[g];
      else        prev_q[g] <= pin[g];
    end
    assign rise[g] =  pin[g] & ~prev_q[g];
    assign fall[g] = ~pin[g] &  prev_q[g];
  end
endmodule

// File: rtl/eespi_array.sv
module eespi_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/eespi_wctl.sv
module eespi_wctl #(
  parameter int BUSY_CYC = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       sr_we,
  input  logic [7:0] sr_wdata,
  input  logic       start_busy,
  output logic       wel,
  output logic [1:0] blk,
  output logic       prot_en,
  output logic       busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(BUSY_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wel_d;
  logic [1:0]    blk_d;
  logic          pen_d;
  logic          last_tick;

  assign busy      = (cnt_q != '0);
  assign last_tick = (cnt_q == CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (start_busy)  cnt_d = CNT_LOAD;
    else if (busy)   cnt_d = cnt_q - CW'(1);

    wel_d = wel;
    if (last_tick)    wel_d = 1'b0;
    else if (set_wel) wel_d = 1'b1;
    else if (clr_wel) wel_d = 1'b0;

    blk_d = blk;
    pen_d = prot_en;
    if (sr_we) begin
      blk_d = sr_wdata[3:2];
      pen_d = sr_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      wel     <= 1'b0;
      blk     <= 2'b00;
      prot_en <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      wel     <= wel_d;
      blk     <= blk_d;
      prot_en <= pen_d;
    end
  end

  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel)); // R6
  AST_WEL_CLR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel); // R9
endmodule

// File: rtl/eespi_slave.sv
module eespi_slave
  import eespi_pkg::*;
#(
  parameter int AW       = 11,
  parameter int BUSY_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  output logic miso
);
  localparam int XAW = 16;

  logic [1:0] pin_rise, pin_fall;
  logic sck_rise, sck_fall, cs_rise;

  eespi_edge #(.N(2), .INIT(2'b10)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin({cs_n, sck}),
    .rise(pin_rise), .fall(pin_fall)
  );
  assign sck_rise = ~cs_n & pin_rise[0];
  assign sck_fall = ~cs_n & pin_fall[0];
  assign cs_rise  = pin_rise[1];

  eespi_st_e st_q, st_d;
  logic [2:0]     bcnt_q, bcnt_d;
  logic [7:0]     rx_q, rx_d, tx_q, tx_d, dat_q, dat_d;
  logic [7:0]     ahi_q, ahi_d;
  logic           abyte_q, abyte_d, isrd_q, isrd_d, hold_q, hold_d;
  logic [AW-1:0]  ptr_q, ptr_d;

  logic [7:0]     rx_full, stat, mem_rdata;
  logic [XAW-1:0] addr_full;
  logic           byte_done;
  logic           set_wel, clr_wel, sr_we, start_busy, mem_we, mem_re;
  logic [AW-1:0]  mem_raddr;
  logic           wel, prot_en, busy;
  logic [1:0]     blk;

  eespi_wctl #(.BUSY_CYC(BUSY_CYC)) u_wctl (
    .clk(clk), .rst_n(rst_n), .set_wel(set_wel), .clr_wel(clr_wel),
    .sr_we(sr_we), .sr_wdata(dat_q), .start_busy(start_busy),
    .wel(wel), .blk(blk), .prot_en(prot_en), .busy(busy)
  );

  eespi_array #(.AW(AW), .DW(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(ptr_q), .wdata(dat_q),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  assign rx_full   = {rx_q[6:0], mosi};
  assign byte_done = sck_rise && (bcnt_q == 3'd7);
  assign addr_full = {ahi_q, rx_full};
  assign stat      = busy ? 8'hFF : {prot_en, 3'b000, blk, wel, 1'b0};
  assign miso      = tx_q[7];

  always_comb begin
    st_d = st_q;  bcnt_d = bcnt_q; rx_d = rx_q;   tx_d = tx_q;
    dat_d = dat_q; ahi_d = ahi_q;  abyte_d = abyte_q;
    isrd_d = isrd_q; hold_d = hold_q; ptr_d = ptr_q;
    set_wel = 1'b0; clr_wel = 1'b0; sr_we = 1'b0; start_busy = 1'b0;
    mem_we = 1'b0;  mem_re = 1'b0;  mem_raddr = ptr_q;

    if (cs_n) begin
      st_d = ST_OPC; bcnt_d = '0; tx_d = '0; hold_d = 1'b0; abyte_d = 1'b0;
      if (cs_rise && bcnt_q == 3'd0 && hold_q && wel && !busy) begin
        if (st_q == ST_WDAT && !blk_hit(blk, ptr_q[AW-1 -: 2])) begin
          mem_we = 1'b1; start_busy = 1'b1;
        end else if (st_q == ST_SRWR && !(!wp_n && prot_en)) begin
          sr_we = 1'b1; start_busy = 1'b1;
        end
      end
    end else begin
      if (sck_rise) begin
        rx_d   = rx_full;
        bcnt_d = bcnt_q + 3'd1;
      end
      if (byte_done) begin
        case (st_q)
          ST_OPC: begin
            st_d = ST_SKIP;
            if (rx_full[7:4] == 4'h0 && (!busy || rx_full[2:0] == OP_RDSR)) begin
              case (rx_full[2:0])
                OP_WREN:  set_wel = 1'b1;
                OP_WRDI:  clr_wel = 1'b1;
                OP_RDSR:  st_d = ST_SRRD;
                OP_WRSR:  st_d = ST_SRWR;
                OP_READ:  begin st_d = ST_ADDR; isrd_d = 1'b1; end
                OP_WRITE: begin st_d = ST_ADDR; isrd_d = 1'b0; end
                default:  st_d = ST_SKIP;
              endcase
            end
          end
          ST_ADDR: begin
            ahi_d   = rx_full;
            abyte_d = 1'b1;
            if (abyte_q) begin
              if (isrd_q) begin
                mem_re    = 1'b1;
                mem_raddr = addr_full[AW-1:0];
                ptr_d     = addr_full[AW-1:0] + AW'(1);
                st_d      = ST_RDAT;
              end else begin
                ptr_d = addr_full[AW-1:0];
                st_d  = ST_WDAT;
              end
            end
          end
          ST_RDAT: begin
            mem_re = 1'b1;
            ptr_d  = ptr_q + AW'(1);
          end
          ST_WDAT, ST_SRWR: begin
            if (!hold_q) begin
              dat_d  = rx_full;
              hold_d = 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (sck_fall) begin
        if (bcnt_q == 3'd0 && st_q == ST_RDAT)      tx_d = mem_rdata;
        else if (bcnt_q == 3'd0 && st_q == ST_SRRD) tx_d = stat;
        else                                        tx_d = {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OPC; bcnt_q <= '0; rx_q <= '0; tx_q <= '0; dat_q <= '0;
      ahi_q <= '0; abyte_q <= 1'b0; isrd_q <= 1'b0; hold_q <= 1'b0; ptr_q <= '0;
    end else begin
      st_q <= st_d; bcnt_q <= bcnt_d; rx_q <= rx_d; tx_q <= tx_d; dat_q <= dat_d;
      ahi_q <= ahi_d; abyte_q <= abyte_d; isrd_q <= isrd_d; hold_q <= hold_d; ptr_q <= ptr_d;
    end
  end

  AST_COMMIT_ON_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || sr_we) |-> cs_n); // R6
  AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !miso); // R1
  AST_BITPOS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bcnt_q == 3'd0)); // R1
  AST_NO_CHANGE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(mem_we || sr_we || set_wel)); // R10
endmodule

// File: tb/tb_eespi_slave.sv
module tb_eespi_slave;
  localparam int AW       = 11;
  localparam int BUSY_CYC = 300;
  localparam int HP       = 4;
  localparam int MASK     = (1 << AW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic miso;
  int   n_vec = 0, n_bad = 0, hi_cnt = 0;

  logic [7:0] mem_m [int];
  logic       m_wel = 1'b0, m_wpen = 1'b0, m_busy = 1'b0;
  logic [1:0] m_bp = 2'b00;

  eespi_slave #(.AW(AW), .BUSY_CYC(BUSY_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .wp_n(wp_n), .miso(miso)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // R1: miso must be low every clock once chip select has been high for two clocks
  always @(negedge clk) begin
    if (rst_n && cs_n) hi_cnt++; else hi_cnt = 0;
    if (hi_cnt >= 2) chk("R1 idle miso", {7'b0, miso}, 8'h00);
  end

  function automatic logic prot(input int a);
    int sz = MASK + 1;
    case (m_bp)
      2'd1:    return a >= (sz * 3) / 4;
      2'd2:    return a >= sz / 2;
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic xbyte(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      mosi = o[b];
      repeat (HP) @(negedge clk);
      i[b] = miso;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo(); cs_n = 1'b0; repeat (2) @(negedge clk); endtask
  task automatic cs_hi(); repeat (2) @(negedge clk); cs_n = 1'b1; repeat (4) @(negedge clk); endtask

  task automatic raw(input logic [7:0] a, input logic [7:0] b, input int nb);
    logic [7:0] d;
    cs_lo(); xbyte(a, d); if (nb > 1) xbyte(b, d); cs_hi();
  endtask

  task automatic t_wren(); raw(8'h06, 8'h00, 1); if (!m_busy) m_wel = 1'b1; endtask
  task automatic t_wrdi(); raw(8'h04, 8'h00, 1); if (!m_busy) m_wel = 1'b0; endtask

  task automatic t_rdsr(input string tag, input int nb);
    logic [7:0] d;
    cs_lo(); xbyte(8'h05, d);
    for (int k = 0; k < nb; k++) begin
      xbyte(8'h00, d);
      chk(tag, d, m_busy ? 8'hFF : {m_wpen, 3'b000, m_bp, m_wel, 1'b0});
    end
    cs_hi();
  endtask

  task automatic t_write(input logic [15:0] a, input logic [7:0] v, input int extra);
    logic [7:0] d;
    int ea = int'(a) & MASK;
    cs_lo(); xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d); xbyte(v, d);
    for (int k = 0; k < extra; k++) xbyte(8'hE0 + 8'(k), d);
    cs_hi();
    if (!m_busy && m_wel && !prot(ea)) begin mem_m[ea] = v; m_busy = 1'b1; end
  endtask

  task automatic t_wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_lo(); xbyte(8'h01, d); xbyte(v, d); cs_hi();
    if (!m_busy && m_wel && !(!wp_n && m_wpen)) begin
      m_bp = v[3:2]; m_wpen = v[7]; m_busy = 1'b1;
    end
  endtask

  task automatic t_wait();
    repeat (BUSY_CYC + 20) @(negedge clk);
    if (m_busy) begin m_busy = 1'b0; m_wel = 1'b0; end
  endtask

  task automatic t_read(input string tag, input logic [15:0] a, input int nb);
    logic [7:0] d;
    cs_lo(); xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int k = 0; k < nb; k++) begin
      xbyte(8'h00, d);
      chk(tag, d, mem_m[(int'(a) + k) & MASK]);
    end
    cs_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    t_rdsr("R3 R4 reset status", 1);
    t_wren();  t_rdsr("R3 R4 latch set, repeated status", 2);
    wp_n = 1'b0; t_wrdi(); t_rdsr("R3 clear with wp_n low", 1); wp_n = 1'b1;

    raw(8'h0E, 8'h00, 1); m_wel = 1'b1; t_rdsr("R2 bit3 ignored set", 1);
    raw(8'h0C, 8'h00, 1); m_wel = 1'b0; t_rdsr("R2 bit3 ignored clear", 1);
    raw(8'h16, 8'h06, 2); t_rdsr("R2 upper nibble rejects", 1);
    raw(8'h07, 8'h06, 2); t_rdsr("R11 unknown opcode skips frame", 1);

    t_wren(); t_write(16'h0010, 8'hA5, 0);
    t_rdsr("R4 R9 busy status", 1);
    t_wrsr(8'h0C);
    t_wait();
    t_rdsr("R9 R10 latch cleared, no status change", 1);
    t_read("R5 R6 read back", 16'h0010, 1);

    t_write(16'h0010, 8'h3C, 0);
    t_read("R6 write without latch", 16'h0010, 1);
    t_rdsr("R6 no busy when refused", 1);

    t_wren(); t_write(16'h0021, 8'h77, 0); t_wait();
    t_wren(); t_write(16'h0020, 8'h11, 1); t_wait();
    t_read("R5 R6 first byte only, increment", 16'h0020, 2);

    t_wren();
    cs_lo(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h30, d); xbyte(8'h55, d);
    for (int b = 0; b < 4; b++) begin
      repeat (HP) @(negedge clk); sck = 1'b1; repeat (HP) @(negedge clk); sck = 1'b0;
    end
    cs_hi();
    t_rdsr("R6 partial byte no commit", 1);
    t_wrdi();

    t_wren(); t_write(16'h07FF, 8'h5A, 0); t_wait();
    t_wren(); t_write(16'h0000, 8'hC3, 0); t_wait();
    t_read("R5 wrap and upper bits ignored", 16'hF7FF, 2);

    t_wren(); t_write(16'h07F0, 8'h42, 0); t_wait();
    t_wren(); t_write(16'h05F0, 8'h10, 0); t_wait();
    t_wren(); t_wrsr(8'h04); t_wait();
    t_rdsr("R7 blk level 1", 1);
    t_wren(); t_write(16'h07F0, 8'h99, 0);
    t_rdsr("R8 refused write keeps latch", 1);
    t_write(16'h05F0, 8'h66, 0); t_wait();
    t_read("R8 top quarter protected", 16'h07F0, 1);
    t_read("R8 below quarter writable", 16'h05F0, 1);

    t_wren(); t_wrsr(8'h08); t_wait();
    t_wren(); t_write(16'h05F0, 8'h77, 0);
    t_write(16'h03F0, 8'h21, 0); t_wait();
    t_read("R8 top half protected", 16'h05F0, 1);
    t_read("R8 lower half writable", 16'h03F0, 1);

    t_wren(); t_wrsr(8'h0C); t_wait();
    t_wren(); t_write(16'h0010, 8'h00, 0);
    t_read("R8 whole array protected", 16'h0010, 1);

    t_wren(); t_wrsr(8'h8C); t_wait();
    t_rdsr("R7 prot_en set", 1);
    wp_n = 1'b0; t_wren(); t_wrsr(8'h00);
    t_rdsr("R7 status write refused under wp_n", 1);
    wp_n = 1'b1; t_wrsr(8'h00); t_wait();
    t_rdsr("R7 status write accepted with wp_n high", 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule